// File: doc/BRIEF.md
# Pseudo Signature Analysis Register

This block compresses a stream of 16-bit words into a 16-bit running signature, so that a block of memory, or a region that should be erased, can be checked against a signature the target computes over the same words. A load strobe seeds the register from a start address and captures how many words the run will cover. Each step strobe then folds in one data word. In erase-check mode the data input is ignored and an all-ones word is folded in instead.

Each step works in a fixed order. If the top bit is set, the register is XORed with the polynomial 0x0805, shifted left by one, and bit 0 is set. Otherwise it is only shifted left by one. The data word, or all ones in erase-check mode, is then XORed into the result. A word counter stops the register once the programmed number of words has been folded in and raises a done flag. While done is high, a compare output reports whether the signature equals an externally supplied expected value. Address generation and the transport of the expected value are left to the surrounding logic.

Top module: `psa_signature`

## Requirements
- R1: While reset is asserted and after it is released, signature reads 0x0000, and done and match read 0. These values hold until the first load.
- R2: A load taken at a clock edge sets signature to startAddr minus 2, modulo 2^16, in the following cycle. The same load captures wordCount as the length of the run in words.
- R3: An accepted step taken while signature bit 15 is 1 produces the value ((signature XOR 0x0805) shifted left by one, bit 0 set to 1) XOR the folded word. The value is visible in the cycle after the edge.
- R4: An accepted step taken while signature bit 15 is 0 produces (signature shifted left by one, bit 0 = 0) XOR the folded word. The value is visible in the cycle after the edge.
- R5: When eraseMode is 1 at a step, the folded word is 0xFFFF and dataWord has no effect. When eraseMode is 0, the folded word is dataWord.
- R6: When seedLoad and stepStrobe are high in the same cycle, only the load takes effect.
- R7: done is 1 exactly when a load has occurred and the number of accepted steps since the last load equals the captured length. A length of 0 gives done = 1 in the cycle after the load. Steps made while done is 1 leave signature unchanged.
- R8: match is 1 only while done is 1 and signature equals expected. It is 0 whenever done is 0.
- R9: Steps made after reset and before the first load are ignored: signature stays 0x0000 and done stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| seedLoad | input | 1 | Seeds the register and captures the run length |
| startAddr | input | 16 | Start address; the seed is this value minus 2 |
| wordCount | input | 8 | Number of words in the run, captured at load |
| stepStrobe | input | 1 | Folds one word into the signature |
| dataWord | input | 16 | Word folded in at a step |
| eraseMode | input | 1 | Folds in all ones instead of dataWord |
| expected | input | 16 | Signature read back from the target |
| signature | output | 16 | Current signature register |
| done | output | 1 | Programmed number of words has been folded in |
| match | output | 1 | done is high and signature equals expected |

## Verification
A load or a step sampled at a rising edge shows up on signature one cycle later, and done follows on that same cycle. match is combinational on expected, so a change of expected is visible within the same cycle. The bench drives inputs just after a falling edge and lets the next rising edge advance a behavioural model. It then compares signature, done and match against that model at the following falling edge, so each result is read in the cycle it is due. Fixed hand-worked values cover the seed, both feedback branches and the erase word.

// File: rtl/psa_pkg.sv
package psa_pkg;

  // Strobes from the control section to the datapath.
  typedef struct packed {
    logic loadEn;   // seed the register this cycle
    logic stepEn;   // fold one word in this cycle
  } psaStrobes_t;

endpackage

// File: rtl/psa_control.sv
module psa_control
  import psa_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             seedLoad,
  input  logic             stepStrobe,
  input  logic [CNT_W-1:0] wordCount,
  output psaStrobes_t      strobes,
  output logic             done
);

  logic [CNT_W-1:0] stepsLeft;
  logic             armed;
  logic             runOpen;

  // A run is open between a load and the last counted word.
  assign runOpen = armed && (stepsLeft != '0);

  // A load always wins; a step counts only inside an open run.
  always_comb begin
    strobes.loadEn = seedLoad;
    strobes.stepEn = !seedLoad && stepStrobe && runOpen;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepsLeft <= '0;
      armed     <= 1'b0;
    end else if (strobes.loadEn) begin
      stepsLeft <= wordCount;
      armed     <= 1'b1;
    end else if (strobes.stepEn) begin
      stepsLeft <= stepsLeft - 1'b1;
    end
  end

  assign done = armed && (stepsLeft == '0);

endmodule

// File: rtl/psa_datapath.sv
module psa_datapath
  import psa_pkg::*;
#(
  parameter int          W           = 16,
  parameter logic [15:0] POLY        = 16'h0805,
  parameter int          SEED_OFFSET = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  psaStrobes_t strobes,
  input  logic [W-1:0] startAddr,
  input  logic [W-1:0] dataWord,
  input  logic        eraseMode,
  input  logic [W-1:0] expected,
  input  logic        done,
  output logic [W-1:0] signature,
  output logic        match
);

  localparam logic [W-1:0] SEED_DELTA = W'(SEED_OFFSET);
  localparam logic [W-1:0] POLY_W     = W'(POLY);

  logic [W-1:0] seedValue;
  logic [W-1:0] foldWord;
  logic [W-1:0] polyMixed;
  logic [W-1:0] shifted;
  logic [W-1:0] nextSig;

  assign seedValue = startAddr - SEED_DELTA;
  assign foldWord  = eraseMode ? {W{1'b1}} : dataWord;
  assign polyMixed = signature ^ POLY_W;

  // Feedback branch: mix polynomial, shift, force bit 0 high.
  always_comb begin
    if (signature[W-1]) begin
      shifted = {polyMixed[W-2:0], 1'b1};
    end else begin
      shifted = {signature[W-2:0], 1'b0};
    end
    nextSig = shifted ^ foldWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      signature <= '0;
    end else if (strobes.loadEn) begin
      signature <= seedValue;
    end else if (strobes.stepEn) begin
      signature <= nextSig;
    end
  end

  assign match = done && (signature == expected);

endmodule

// File: rtl/psa_signature.sv
module psa_signature
  import psa_pkg::*;
#(
  parameter int          W           = 16,
  parameter int          CNT_W       = 8,
  parameter logic [15:0] POLY        = 16'h0805,
  parameter int          SEED_OFFSET = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             seedLoad,
  input  logic [W-1:0]     startAddr,
  input  logic [CNT_W-1:0] wordCount,
  input  logic             stepStrobe,
  input  logic [W-1:0]     dataWord,
  input  logic             eraseMode,
  input  logic [W-1:0]     expected,
  output logic [W-1:0]     signature,
  output logic             done,
  output logic             match
);

  psaStrobes_t strobes;

  psa_control #(.CNT_W(CNT_W)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .seedLoad  (seedLoad),
    .stepStrobe(stepStrobe),
    .wordCount (wordCount),
    .strobes   (strobes),
    .done      (done)
  );

  psa_datapath #(.W(W), .POLY(POLY), .SEED_OFFSET(SEED_OFFSET)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .startAddr(startAddr),
    .dataWord (dataWord),
    .eraseMode(eraseMode),
    .expected (expected),
    .done     (done),
    .signature(signature),
    .match    (match)
  );

endmodule

// File: rtl/psa_checker.sv
module psa_checker #(
  parameter int          W     = 16,
  parameter int          CNT_W = 8,
  parameter logic [15:0] POLY  = 16'h0805
) (
  input logic             clk,
  input logic             rstN,
  input logic             seedLoad,
  input logic [W-1:0]     startAddr,
  input logic [CNT_W-1:0] wordCount,
  input logic             stepStrobe,
  input logic [W-1:0]     dataWord,
  input logic             eraseMode,
  input logic [W-1:0]     expected,
  input logic [W-1:0]     signature,
  input logic             done,
  input logic             match
);

  logic seenLoad;
  logic [W-1:0] mixedWord;
  logic [W-1:0] predicted;
  logic acceptStep;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenLoad <= 1'b0;
    else if (seedLoad) seenLoad <= 1'b1;
  end

  always_comb begin
    mixedWord = eraseMode ? {W{1'b1}} : dataWord;
    if (signature[W-1]) predicted = (((signature ^ W'(POLY)) << 1) | W'(1)) ^ mixedWord;
    else                predicted = (signature << 1) ^ mixedWord;
  end

  assign acceptStep = seenLoad && !seedLoad && stepStrobe && !done;

  // R2 and R6: a load (winning over any step) seeds with start minus two
  a_r2_seed: assert property (@(posedge clk) disable iff (!rstN)
    seedLoad |=> signature == $past(startAddr) - W'(2));

  // R3, R4, R5: one accepted step applies the fold rule
  a_r3_fold_step: assert property (@(posedge clk) disable iff (!rstN)
    acceptStep |=> signature == $past(predicted));

  // R7: once done, steps leave the signature alone
  a_r7_hold_done: assert property (@(posedge clk) disable iff (!rstN)
    (done && !seedLoad) |=> ($stable(signature) && done));

  // R8: match implies done and equality
  a_r8_match_valid: assert property (@(posedge clk) disable iff (!rstN)
    match |-> (done && signature == expected));

  // R9: nothing happens before the first load
  a_r9_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!seenLoad && !seedLoad) |=> (!done && signature == '0));

  logic unusedBits;
  assign unusedBits = ^wordCount;

endmodule

bind psa_signature psa_checker #(.W(W), .CNT_W(CNT_W), .POLY(POLY)) uChk (.*);

// File: tb/sim_psa_signature.sv
module sim_psa_signature;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        seedLoad = 1'b0;
  logic [15:0] startAddr = '0;
  logic [7:0]  wordCount = '0;
  logic        stepStrobe = 1'b0;
  logic [15:0] dataWord = '0;
  logic        eraseMode = 1'b0;
  logic [15:0] expected = '0;
  logic [15:0] signature;
  logic        done;
  logic        match;

  always #4 clk = ~clk;

  psa_signature u0 (
    .clk(clk), .rstN(rstN), .seedLoad(seedLoad), .startAddr(startAddr),
    .wordCount(wordCount), .stepStrobe(stepStrobe), .dataWord(dataWord),
    .eraseMode(eraseMode), .expected(expected), .signature(signature),
    .done(done), .match(match)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  // Behavioural reference model
  int mSig = 0;
  int mLeft = 0;
  bit mArmed = 0;

  always @(posedge clk) begin
    if (!rstN) begin
      mSig = 0; mLeft = 0; mArmed = 0;
    end else if (seedLoad) begin
      mSig = (int'(startAddr) - 2) & 16'hFFFF;
      mLeft = wordCount;
      mArmed = 1;
    end else if (stepStrobe && mArmed && mLeft > 0) begin
      if (mSig >= 32768) mSig = (((mSig ^ 16'h0805) * 2) + 1) & 16'hFFFF;
      else               mSig = (mSig * 2) & 16'hFFFF;
      mSig = mSig ^ (eraseMode ? 16'hFFFF : int'(dataWord));
      mLeft = mLeft - 1;
    end
  end

  function automatic bit modelDone();
    return mArmed && (mLeft == 0);
  endfunction

  task automatic check(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
    end
  endtask

  task automatic tick(string tag);
    @(posedge clk);
    @(negedge clk);
    check({tag, " signature"}, int'(signature), mSig);
    check({tag, " done"}, int'(done), int'(modelDone()));
    check({tag, " match"}, int'(match),
          int'(modelDone() && (mSig == int'(expected))));
  endtask

  task automatic loadRun(logic [15:0] addr, logic [7:0] len, string tag);
    seedLoad = 1'b1; startAddr = addr; wordCount = len;
    tick(tag);
    seedLoad = 1'b0;
  endtask

  task automatic stepWord(logic [15:0] d, logic er, string tag);
    stepStrobe = 1'b1; dataWord = d; eraseMode = er;
    tick(tag);
    stepStrobe = 1'b0; eraseMode = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick("R1 in reset");
    tick("R1 in reset");
    rstN = 1'b1;
    tick("R1 after reset");
    check("R1 signature zero", int'(signature), 0);
    check("R1 done low", int'(done), 0);

    // R9: step before any load
    stepWord(16'hBEEF, 1'b0, "R9 step before load");
    check("R9 signature unchanged", int'(signature), 0);
    check("R9 done low", int'(done), 0);

    // R2/R4 hand values
    loadRun(16'h0002, 8'd3, "R2 seed");
    check("R2 seed 0x0002-2", int'(signature), 16'h0000);
    stepWord(16'h1234, 1'b0, "R4 shift only");
    check("R4 hand value", int'(signature), 16'h1234);

    // R3 hand value: 0x8000 -> ((0x8805<<1)|1) = 0x100B
    loadRun(16'h8002, 8'd2, "R3 seed");
    stepWord(16'h0000, 1'b0, "R3 feedback");
    check("R3 hand value", int'(signature), 16'h100B);

    // R5: erase folds all ones regardless of data
    loadRun(16'h0002, 8'd1, "R5 seed");
    stepWord(16'h1357, 1'b1, "R5 erase word");
    check("R5 erase value", int'(signature), 16'hFFFF);
    check("R7 done after one word", int'(done), 1);
    expected = 16'hFFFF;
    tick("R8 equal");
    check("R8 match high", int'(match), 1);
    expected = 16'hFFFE;
    tick("R8 unequal");
    check("R8 match low", int'(match), 0);

    // R7: steps while done are ignored
    expected = 16'hFFFF;
    stepWord(16'h0F0F, 1'b0, "R7 step after done");
    check("R7 signature held", int'(signature), 16'hFFFF);

    // R7: zero length is done at once; seed wraps modulo 2^16
    loadRun(16'h0001, 8'd0, "R7 zero length");
    check("R2 wrap seed", int'(signature), 16'hFFFF);
    check("R7 zero length done", int'(done), 1);

    // R6: load wins over step
    stepStrobe = 1'b1; dataWord = 16'hAAAA;
    loadRun(16'h4000, 8'd4, "R6 load with step");
    stepStrobe = 1'b0;
    check("R6 seed only", int'(signature), 16'h3FFE);
    check("R8 not done no match", int'(match), 0);

    // Random runs against the model
    for (int run = 0; run < 40; run++) begin
      int len;
      len = 1 + ($urandom % 24);
      loadRun(16'($urandom), 8'(len), "R2 random seed");
      for (int w = 0; w < len + 2; w++) begin
        if ($urandom % 4 == 0) tick("R7 idle gap");
        stepWord(16'($urandom), 1'(($urandom % 5) == 0), "R3 R4 R5 random step");
      end
      expected = ($urandom % 2 == 0) ? 16'(mSig) : 16'(mSig ^ 1);
      tick("R8 random compare");
    end

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule